// File: doc/BRIEF.md
# Two-Dimensional Parity Flit-Group Decoder

This block sits at the receiving end of an on-chip link that protects its traffic with a row-and-column parity code. Traffic arrives in groups. Each group has a fixed number of data flits, and a check flit follows them. Every flit carries its data bits and one parity bit above them, in the top position. The check flit holds, for each bit position, the even parity of that position across the data flits. Its top bit covers the parity-bit column of the data flits.

While a group streams in, the decoder stores the data flits. It records one parity result per data flit (the row checks) and folds every flit, the check flit included, into a running column XOR. The decoder then sorts the group into one of three outcomes. A clean group passes through unchanged. A group with one detectable error is repaired: the bit where the failing row meets the failing column is inverted as that flit is read out. A group with more damage passes through as received, and the decoder raises a request that lists the bit positions the sender should resend. A one-cycle done pulse marks each classification. The counts of failing rows and columns come out with it, so that a rate controller can use them.

Top module: `xgrid_decoder`

## Requirements
- R1: For each data flit, the row check is the XOR of all its bits, the parity bit at index DATA_W included. The count of data flits whose row check is 1 appears on `row_fail_cnt` while `grp_done` is high.
- R2: The column vector is the bitwise XOR of all GROUP_FLITS data flits and the check flit. The number of ones in it appears on `col_fail_cnt` while `grp_done` is high.
- R3: When the row count and the column count are both zero, `grp_status` is 0 (clean). The data flits leave in arrival order, bit for bit as received.
- R4: When exactly one row check and exactly one column bit are set, `grp_status` is 1 (corrected). The data flit with the failing row leaves with the failing column bit inverted. Every other flit leaves unchanged.
- R5: When no row check is set and exactly one column bit is set, `grp_status` is 1. In this case the fault lies in the check flit, and all data flits leave unchanged.
- R6: `grp_status` is 2 (multiple) when the row count exceeds 1, when the column count exceeds 1, or when the row count is 1 and the column count is 0. In every such case the data flits leave exactly as received.
- R7: When `grp_status` is 2, `resend_mask` equals the column vector, and each set bit names a bit index to resend. For status 0 or 1, `resend_mask` is zero.
- R8: `grp_done` is high for exactly one cycle, two cycles after the check flit is accepted. `grp_status`, `resend_mask` and both counts hold their values until the next pulse.
- R9: `in_ready` is low from the cycle after the check flit is accepted until the last data flit of that group has been taken at the output. No new group begins while the previous one drains.
- R10: Four flipped bits at the corners of a rectangle (two flits, two bit positions) cancel in both checks. The group is reported clean and leaves as received.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_flit` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Incoming flit is valid |
| in_ready | output | 1 | Decoder accepts a flit |
| in_flit | input | DATA_W+1 | Incoming flit, parity bit at index DATA_W |
| out_valid | output | 1 | Outgoing data flit is valid |
| out_ready | input | 1 | Downstream takes the flit |
| out_flit | output | DATA_W+1 | Outgoing (possibly corrected) data flit |
| grp_done | output | 1 | One-cycle pulse when a group is classified |
| grp_status | output | 2 | 0 clean, 1 corrected, 2 multiple errors |
| resend_mask | output | DATA_W+1 | Bit indices to resend when status is 2 |
| row_fail_cnt | output | clog2(GROUP_FLITS+1) | Number of failing data-flit row checks |
| col_fail_cnt | output | clog2(DATA_W+2) | Number of set bits in the column vector |

## Verification
The bench builds the decoder with 8 data bits and a group of 4 data flits. With a grid this small, every fault class can be placed by hand: a corner data bit, a flit's own parity bit, a data bit of the check flit and its corner bit, a double flip inside one flit, a double flip down one column, a diagonal pair, a triple flip, and the undetectable rectangle. Each group is drained under an `out_ready` pattern that stalls often. This covers the readout correction and the output hold, and the groups run back to back.

// File: rtl/xgrid_pkg.sv
package xgrid_pkg;

   typedef enum logic [1:0] {
      GRP_CLEAN = 2'd0,
      GRP_FIXED = 2'd1,
      GRP_MULTI = 2'd2
   } grp_status_e;

   typedef enum logic [1:0] {
      PH_COLLECT = 2'd0,
      PH_EVAL    = 2'd1,
      PH_DRAIN   = 2'd2
   } phase_e;

endpackage

// File: rtl/xgrid_check_accum.sv
module xgrid_check_accum #(
   parameter int DATA_W      = 16,
   parameter int GROUP_FLITS = 4
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   take,
   input  logic [$clog2(GROUP_FLITS+1)-1:0]       idx,
   input  logic [DATA_W:0]                        flit,
   output logic [GROUP_FLITS-1:0]                 row_chk,
   output logic [DATA_W:0]                        col_vec
);
   localparam int FW = DATA_W + 1;
   localparam int IW = $clog2(GROUP_FLITS + 1);

   logic flit_odd;
   assign flit_odd = ^flit;

   // one row-check bit per data flit position
   for (genvar g = 0; g < GROUP_FLITS; g++) begin : g_row
      logic chk_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            chk_q <= 1'b0;
         else if (take && idx == IW'(g))
            chk_q <= flit_odd;
      end
      assign row_chk[g] = chk_q;
   end

   // column accumulator: loaded on flit 0, folded on every later flit
   logic [FW-1:0] col_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         col_q <= '0;
      else if (take) begin
         if (idx == '0)
            col_q <= flit;
         else
            col_q <= col_q ^ flit;
      end
   end
   assign col_vec = col_q;

endmodule

// File: rtl/xgrid_flit_store.sv
module xgrid_flit_store #(
   parameter int DATA_W      = 16,
   parameter int GROUP_FLITS = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wen,
   input  logic [$clog2(GROUP_FLITS+1)-1:0] wr_idx,
   input  logic [DATA_W:0]                  wr_flit,
   input  logic [$clog2(GROUP_FLITS+1)-1:0] rd_idx,
   output logic [DATA_W:0]                  rd_flit,
   output logic                             rd_row
);
   localparam int FW = DATA_W + 1;
   localparam int IW = $clog2(GROUP_FLITS + 1);

   logic [FW-1:0] ent [GROUP_FLITS];

   for (genvar g = 0; g < GROUP_FLITS; g++) begin : g_ent
      logic [FW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wen && wr_idx == IW'(g))
            q <= wr_flit;
      end
      assign ent[g] = q;
   end

   // rd_row flags that the read index addresses a real entry
   always_comb begin
      rd_flit = '0;
      rd_row  = 1'b0;
      for (int k = 0; k < GROUP_FLITS; k++) begin
         if (rd_idx == IW'(k)) begin
            rd_flit = ent[k];
            rd_row  = 1'b1;
         end
      end
   end

endmodule

// File: rtl/xgrid_classify.sv
module xgrid_classify
   import xgrid_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int GROUP_FLITS = 4
) (
   input  logic [GROUP_FLITS-1:0]             row_chk,
   input  logic [DATA_W:0]                    col_vec,
   output logic [$clog2(GROUP_FLITS+1)-1:0]   row_cnt,
   output logic [$clog2(DATA_W+2)-1:0]        col_cnt,
   output grp_status_e                        status
);
   localparam int RCW = $clog2(GROUP_FLITS + 1);
   localparam int CCW = $clog2(DATA_W + 2);

   always_comb begin
      row_cnt = RCW'($countones(row_chk));
      col_cnt = CCW'($countones(col_vec));
      if (row_cnt == '0 && col_cnt == '0)
         status = GRP_CLEAN;
      else if (row_cnt > RCW'(1) || col_cnt > CCW'(1) || col_cnt == '0)
         status = GRP_MULTI;
      else
         status = GRP_FIXED;
   end

endmodule

// File: rtl/xgrid_decoder.sv
module xgrid_decoder
   import xgrid_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int GROUP_FLITS = 4
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 in_valid,
   output logic                                 in_ready,
   input  logic [DATA_W:0]                      in_flit,
   output logic                                 out_valid,
   input  logic                                 out_ready,
   output logic [DATA_W:0]                      out_flit,
   output logic                                 grp_done,
   output logic [1:0]                           grp_status,
   output logic [DATA_W:0]                      resend_mask,
   output logic [$clog2(GROUP_FLITS+1)-1:0]     row_fail_cnt,
   output logic [$clog2(DATA_W+2)-1:0]          col_fail_cnt
);
   localparam int FW  = DATA_W + 1;
   localparam int IW  = $clog2(GROUP_FLITS + 1);
   localparam int RCW = $clog2(GROUP_FLITS + 1);
   localparam int CCW = $clog2(DATA_W + 2);
   localparam logic [IW-1:0] LAST_IN  = IW'(GROUP_FLITS);
   localparam logic [IW-1:0] LAST_OUT = IW'(GROUP_FLITS - 1);

   if (DATA_W < 2) begin : g_bad_width
      $error("xgrid_decoder: DATA_W must be at least 2");
   end
   if (GROUP_FLITS < 2) begin : g_bad_group
      $error("xgrid_decoder: GROUP_FLITS must be at least 2");
   end

   phase_e        ph;
   logic [IW-1:0] wr_idx, rd_idx;
   logic          take, give;

   assign in_ready  = (ph == PH_COLLECT);
   assign out_valid = (ph == PH_DRAIN);
   assign take      = in_valid && in_ready;
   assign give      = out_valid && out_ready;

   logic [GROUP_FLITS-1:0] row_chk;
   logic [FW-1:0]          col_vec;

   xgrid_check_accum #(.DATA_W(DATA_W), .GROUP_FLITS(GROUP_FLITS)) u_accum (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .idx     (wr_idx),
      .flit    (in_flit),
      .row_chk (row_chk),
      .col_vec (col_vec)
   );

   logic [FW-1:0] rd_flit;
   logic          rd_row;

   xgrid_flit_store #(.DATA_W(DATA_W), .GROUP_FLITS(GROUP_FLITS)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wen     (take && wr_idx != LAST_IN),
      .wr_idx  (wr_idx),
      .wr_flit (in_flit),
      .rd_idx  (rd_idx),
      .rd_flit (rd_flit),
      .rd_row  (rd_row)
   );

   logic [RCW-1:0] cls_rcnt;
   logic [CCW-1:0] cls_ccnt;
   grp_status_e    cls_status;

   xgrid_classify #(.DATA_W(DATA_W), .GROUP_FLITS(GROUP_FLITS)) u_cls (
      .row_chk (row_chk),
      .col_vec (col_vec),
      .row_cnt (cls_rcnt),
      .col_cnt (cls_ccnt),
      .status  (cls_status)
   );

   logic           done_q, fix_q;
   grp_status_e    status_q;
   logic [FW-1:0]  mask_q;
   logic [RCW-1:0] rcnt_q;
   logic [CCW-1:0] ccnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= PH_COLLECT;
         wr_idx   <= '0;
         rd_idx   <= '0;
         done_q   <= 1'b0;
         fix_q    <= 1'b0;
         status_q <= GRP_CLEAN;
         mask_q   <= '0;
         rcnt_q   <= '0;
         ccnt_q   <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (ph)
            PH_COLLECT: begin
               if (take) begin
                  if (wr_idx == LAST_IN) begin
                     wr_idx <= '0;
                     ph     <= PH_EVAL;
                  end else begin
                     wr_idx <= wr_idx + IW'(1);
                  end
               end
            end
            PH_EVAL: begin
               done_q   <= 1'b1;
               status_q <= cls_status;
               mask_q   <= (cls_status == GRP_MULTI) ? col_vec : '0;
               fix_q    <= (cls_status == GRP_FIXED) && (cls_rcnt != '0);
               rcnt_q   <= cls_rcnt;
               ccnt_q   <= cls_ccnt;
               rd_idx   <= '0;
               ph       <= PH_DRAIN;
            end
            PH_DRAIN: begin
               if (give) begin
                  if (rd_idx == LAST_OUT) begin
                     rd_idx <= '0;
                     ph     <= PH_COLLECT;
                  end else begin
                     rd_idx <= rd_idx + IW'(1);
                  end
               end
            end
            default: ph <= PH_COLLECT;
         endcase
      end
   end

   // failing row of the current read slot; row_chk and col_vec stay put while draining
   logic rd_row_bad;
   always_comb begin
      rd_row_bad = 1'b0;
      for (int k = 0; k < GROUP_FLITS; k++)
         if (rd_idx == IW'(k)) rd_row_bad = row_chk[k];
   end

   assign out_flit     = (fix_q && rd_row && rd_row_bad) ? (rd_flit ^ col_vec) : rd_flit;
   assign grp_done     = done_q;
   assign grp_status   = status_q;
   assign resend_mask  = mask_q;
   assign row_fail_cnt = rcnt_q;
   assign col_fail_cnt = ccnt_q;

endmodule

// File: rtl/xgrid_decoder_chk.sv
module xgrid_decoder_chk #(
   parameter int DATA_W      = 16,
   parameter int GROUP_FLITS = 4
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             in_valid,
   input logic                             in_ready,
   input logic [DATA_W:0]                  in_flit,
   input logic                             out_valid,
   input logic                             out_ready,
   input logic [DATA_W:0]                  out_flit,
   input logic                             grp_done,
   input logic [1:0]                       grp_status,
   input logic [DATA_W:0]                  resend_mask,
   input logic [$clog2(GROUP_FLITS+1)-1:0] row_fail_cnt,
   input logic [$clog2(DATA_W+2)-1:0]      col_fail_cnt
);

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      grp_done |=> !grp_done);

   p_done_starts_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
      grp_done |-> out_valid);

   p_no_accept_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   p_hold_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_flit)));

   p_mask_only_multi_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_done && grp_status != 2'd2) |-> (resend_mask == '0));

   p_multi_rule_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_done && (row_fail_cnt > 1 || col_fail_cnt > 1)) |-> (grp_status == 2'd2));

   p_mask_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_done && grp_status == 2'd2) |-> ($countones(resend_mask) == int'(col_fail_cnt)));

   p_status_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!grp_done && $past(!grp_done)) |-> $stable(grp_status));

endmodule

bind xgrid_decoder xgrid_decoder_chk #(.DATA_W(DATA_W), .GROUP_FLITS(GROUP_FLITS)) u_chk (.*);

// File: tb/xgrid_decoder_bench.sv
module xgrid_decoder_bench;
   localparam int N  = 8;
   localparam int M  = 4;
   localparam int FW = N + 1;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   typedef logic [FW-1:0] flit_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready;
   flit_t in_flit = '0;
   logic out_valid;
   logic out_ready = 1'b0;
   flit_t out_flit;
   logic grp_done;
   logic [1:0] grp_status;
   flit_t resend_mask;
   logic [$clog2(M+1)-1:0] row_fail_cnt;
   logic [$clog2(N+2)-1:0] col_fail_cnt;

   always #(CLK_PERIOD/2) clk = ~clk;

   xgrid_decoder #(.DATA_W(N), .GROUP_FLITS(M)) u_xgrid_decoder (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
      .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit),
      .grp_done(grp_done), .grp_status(grp_status), .resend_mask(resend_mask),
      .row_fail_cnt(row_fail_cnt), .col_fail_cnt(col_fail_cnt)
   );

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;

   flit_t exp_q[$];
   int    st_q[$];
   flit_t mask_q[$];
   int    rc_q[$];
   int    cc_q[$];
   string tag_q[$];

   flit_t err_a [M+1];

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clear_err();
      for (int i = 0; i <= M; i++) err_a[i] = '0;
   endtask

   // driver: builds a group, injects err_a, predicts results, sends it
   task automatic run_group(input int seed, input string req);
      flit_t orig [M+1];
      flit_t tx [M+1];
      flit_t pf, col;
      logic [N-1:0] d;
      int rows, ccnt, st;
      pf = '0;
      for (int i = 0; i < M; i++) begin
         d = N'(seed * 37 + i * 91 + 5);
         orig[i] = {^d, d};
         pf ^= orig[i];
      end
      orig[M] = pf;
      rows = 0;
      col = '0;
      for (int i = 0; i <= M; i++) begin
         tx[i] = orig[i] ^ err_a[i];
         col ^= err_a[i];
         if (i < M && (^err_a[i])) rows++;
      end
      ccnt = $countones(col);
      if (rows == 0 && ccnt == 0) st = 0;
      else if (rows > 1 || ccnt > 1 || ccnt == 0) st = 2;
      else st = 1;
      st_q.push_back(st);
      mask_q.push_back(st == 2 ? col : '0);
      rc_q.push_back(rows);
      cc_q.push_back(ccnt);
      tag_q.push_back(req);
      for (int i = 0; i < M; i++) exp_q.push_back(st == 1 ? orig[i] : tx[i]);
      for (int i = 0; i <= M; i++) begin
         in_valid = 1'b1;
         in_flit  = tx[i];
         @(negedge clk);
         while (!in_ready) @(negedge clk);
         @(posedge clk);
         #1;
      end
      in_valid = 1'b0;
      in_flit  = '0;
   endtask

   // output stall pattern
   int cyc = 0;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      #1 out_ready = (cyc % 3) != 1;
   end

   // monitor
   bit    prev_done = 0;
   bit    prev_stall = 0;
   flit_t prev_flit = '0;
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (prev_stall) begin
            check(out_valid && out_flit == prev_flit, "R11 hold under stall", out_flit, prev_flit);
         end
         prev_stall = out_valid && !out_ready;
         prev_flit  = out_flit;
         if (prev_done) check(!grp_done, "R8 done lasts one cycle", grp_done, 0);
         prev_done = grp_done;
         if (grp_done) begin
            if (st_q.size() == 0) check(0, "R8 unexpected done", 1, 0);
            else begin
               string t;
               int es, er, ec;
               flit_t em;
               t = tag_q.pop_front();
               es = st_q.pop_front(); em = mask_q.pop_front();
               er = rc_q.pop_front(); ec = cc_q.pop_front();
               check(grp_status == 2'(es), {t, " status"}, grp_status, es);
               check(resend_mask == em, "R7 resend mask", resend_mask, em);
               check(int'(row_fail_cnt) == er, "R1 row fail count", row_fail_cnt, er);
               check(int'(col_fail_cnt) == ec, "R2 column fail count", col_fail_cnt, ec);
            end
         end
         if (out_valid) check(!in_ready, "R9 in_ready low while draining", in_ready, 0);
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) check(0, "R3 unexpected flit", out_flit, 0);
            else begin
               flit_t e;
               e = exp_q.pop_front();
               check(out_flit == e, {tag_q.size() >= 0 ? "R3/R4/R5/R6 flit data" : ""}, out_flit, e);
            end
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b1, "R9 reset in_ready", in_ready, 1);
      check(out_valid == 1'b0, "R3 reset out_valid", out_valid, 0);
      check(grp_done == 1'b0, "R8 reset done", grp_done, 0);
      @(posedge clk); #1;

      clear_err(); run_group(1, "R3 clean");
      clear_err(); err_a[2] = flit_t'(1 << 5); run_group(2, "R4 data bit");
      clear_err(); err_a[1] = flit_t'(1 << N); run_group(3, "R4 flit parity bit");
      clear_err(); err_a[3] = flit_t'(1 << (N-1)); run_group(4, "R4 top data bit");
      clear_err(); err_a[M] = flit_t'(1 << 3); run_group(5, "R5 check flit bit");
      clear_err(); err_a[M] = flit_t'(1 << N); run_group(6, "R5 check flit corner");
      clear_err(); err_a[0] = flit_t'(9'h006); run_group(7, "R6 R7 double in flit");
      clear_err(); err_a[1] = flit_t'(1 << 4); err_a[3] = flit_t'(1 << 4); run_group(8, "R6 double in column");
      clear_err(); err_a[0] = flit_t'(1); err_a[3] = flit_t'(1 << 7); run_group(9, "R6 R7 diagonal");
      clear_err(); err_a[0] = flit_t'(9'h007); run_group(10, "R6 triple in flit");
      clear_err(); err_a[0] = flit_t'(9'h044); err_a[2] = flit_t'(9'h044); run_group(11, "R10 rectangle");
      clear_err(); run_group(12, "R3 clean again");

      while (exp_q.size() != 0 || st_q.size() != 0) @(posedge clk);
      repeat (4) @(posedge clk);
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected 0 pending flits", exp_q.size());
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule